// File: doc/BRIEF.md
# Link Event Synchronization Checker

This block watches the word stream from one front-end readout link on the receiving side. It splits the 32-bit words into event fragments and takes the bunch number and event number from each fragment header. It then checks both numbers against reference values. The reference values are built locally from the trigger accepts of the timing stream and are queued in a small first-in first-out store. Each accept pushes one entry, and each header pops one. A fragment is a header word, a fixed number of payload words and one idle separator word.

Several kinds of fault send the parser into a hunt state: an ID mismatch, a header that arrives with no reference waiting, or a fragment of the wrong length. In the hunt state it throws words away until a single idle separator arrives, and then it is framed again. Saturating counters record valid words, good events, mismatches, framing errors, unexpected events and resynchronisations, and a clear strobe zeroes them. A sticky flag holds the received and expected IDs of the first mismatch for later inspection.

The parser has four named states. WAIT_HDR expects a header and tolerates idles. PAYLOAD counts the payload words. WAIT_SEP expects the separator. HUNT discards words until an idle arrives. The transitions are:
- WAIT_HDR to PAYLOAD on a matching header.
- WAIT_HDR to HUNT on a mismatch, an unexpected header or a non-header word.
- PAYLOAD to WAIT_SEP on the last payload word.
- PAYLOAD to WAIT_HDR on an early idle.
- WAIT_SEP to WAIT_HDR on an idle.
- WAIT_SEP to HUNT on an extra word.
- HUNT to WAIT_HDR on an idle.

Top module: `link_sync_checker`

## Requirements
- R1: After reset every counter is zero, the sticky flag and capture registers are zero, and the parser is in WAIT_HDR.
- R2: The word counter counts every cycle with rx_valid high, in any parser state. Cycles with rx_valid low have no effect on any counter or on the parser.
- R3: The idle separator is the word IDLE_WORD (default 0xBC50BC50). A header has 0xE5 in bits 31:24, the bunch number in bits BX_W-1:0 and the event number in bits 12+EV_W-1:12. A fragment is a header, then PAYLOAD_LEN non-idle words, then one idle. A header whose IDs equal the reference at the queue head increments the event counter.
- R4: trig_accept pushes {trig_bx, trig_ev} into the reference queue, which holds REF_DEPTH entries. A push into a full queue is dropped. Every header taken in WAIT_HDR pops one entry when the queue is not empty, and entries are used in push order.
- R5: A header that arrives in WAIT_HDR while the queue is empty increments the unexpected-event counter, pops nothing and enters HUNT.
- R6: A header whose bunch number or event number differs from the reference increments the mismatch counter, consumes the reference and enters HUNT.
- R7: A non-idle, non-header word in WAIT_HDR, or a non-idle word in WAIT_SEP, increments the framing counter and enters HUNT.
- R8: An idle word that arrives in PAYLOAD before PAYLOAD_LEN payload words increments both the framing and the resync counters, and the parser returns to WAIT_HDR.
- R9: In HUNT every non-idle word is discarded, including headers, which pop no reference. The first idle word increments the resync counter and returns the parser to WAIT_HDR.
- R10: Every counter stops at all-ones and does not wrap.
- R11: A ctrl_clr cycle zeroes every counter, the sticky flag and the captures on the next edge. Clearing takes priority over any increment in that cycle.
- R12: On the first mismatch after reset or clear, err_sticky rises and the received and reference IDs are captured. Later mismatches leave the captures unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | rx_word holds a received word |
| rx_word | input | 32 | Received link word |
| trig_accept | input | 1 | Local trigger accept; pushes a reference |
| trig_bx | input | BX_W | Reference bunch number |
| trig_ev | input | EV_W | Reference event number |
| ctrl_clr | input | 1 | Clear strobe for counters and sticky state |
| cnt_words | output | CNT_W | Valid words received |
| cnt_events | output | CNT_W | Headers that matched the reference |
| cnt_mismatch | output | CNT_W | ID mismatches |
| cnt_framing | output | CNT_W | Framing and length errors |
| cnt_unexpected | output | CNT_W | Headers that arrived with no reference queued |
| cnt_resync | output | CNT_W | Exits from hunt on an idle word |
| err_sticky | output | 1 | First mismatch seen |
| cap_rx_bx | output | BX_W | Captured received bunch number |
| cap_rx_ev | output | EV_W | Captured received event number |
| cap_ref_bx | output | BX_W | Captured reference bunch number |
| cap_ref_ev | output | EV_W | Captured reference event number |

## Verification
A parser left in the wrong state shows up on the next fragment boundary. The following idle or header then moves the framing, resync or event counter by a count that differs from the one a reference model predicts. Checking at each fragment boundary therefore catches the fault within one fragment. If the reference queue falls out of step, the next matching fragment turns into a mismatch or an unexpected event, which becomes visible one cycle after that header. The bench compares all six counters and the capture registers against a bench-side protocol model. It does this after every directed sequence and after every group of random fragments.

// File: rtl/link_sync_pkg.sv
package link_sync_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_HDR = 2'd0,
        ST_PAYLOAD  = 2'd1,
        ST_WAIT_SEP = 2'd2,
        ST_HUNT     = 2'd3
    } parse_state_t;

    // event pulse indices, one saturating counter each
    localparam int EVT_WORD   = 0;
    localparam int EVT_GOOD   = 1;
    localparam int EVT_MISM   = 2;
    localparam int EVT_FRAME  = 3;
    localparam int EVT_UNEXP  = 4;
    localparam int EVT_RESYNC = 5;
    localparam int EVT_NUM    = 6;

    localparam logic [7:0] HDR_MARK = 8'hE5;
    localparam int         EV_LSB   = 12;

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != MAXV)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10: never wraps, never drops without a clear
    a_r10_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt >= $past(cnt)));
    a_r10_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> (cnt == MAXV));
    // R11: clear wins
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/ref_fifo.sv
module ref_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;
    logic [AW:0]  occ;
    logic         full;
    logic         do_push;
    logic         do_pop;

    assign occ     = wp - rp;
    assign empty   = (occ == '0);
    assign full    = (occ == DEPTH_L);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp[AW-1:0]] <= din;
    end

    // R4: the parser never pops an empty queue
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R4: a push into a full queue leaves it full and unchanged in size
    a_r4_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/frame_parser.sv
module frame_parser
    import link_sync_pkg::*;
#(
    parameter int          BX_W        = 12,
    parameter int          EV_W        = 12,
    parameter int          PAYLOAD_LEN = 4,
    parameter logic [31:0] IDLE_WORD   = 32'hBC50_BC50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [31:0]         rx_word,
    input  logic                ref_empty,
    input  logic [BX_W-1:0]     ref_bx,
    input  logic [EV_W-1:0]     ref_ev,
    output logic                ref_pop,
    output logic [EVT_NUM-1:0]  evt,
    output logic [BX_W-1:0]     hdr_bx,
    output logic [EV_W-1:0]     hdr_ev
);
    localparam int          RW     = $clog2(PAYLOAD_LEN + 1);
    localparam logic [RW-1:0] LEN_L = RW'(PAYLOAD_LEN);

    parse_state_t st, st_nxt;
    logic [RW-1:0] rem, rem_nxt;
    logic          is_idle;
    logic          is_hdr;
    logic          ids_match;

    assign is_idle   = (rx_word == IDLE_WORD);
    assign is_hdr    = (rx_word[31:24] == HDR_MARK);
    assign hdr_bx    = rx_word[BX_W-1:0];
    assign hdr_ev    = rx_word[EV_LSB +: EV_W];
    assign ids_match = (hdr_bx == ref_bx) && (hdr_ev == ref_ev);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_WAIT_HDR;
            rem <= '0;
        end else begin
            st  <= st_nxt;
            rem <= rem_nxt;
        end
    end

    // next state and event pulses
    always_comb begin
        st_nxt  = st;
        rem_nxt = rem;
        ref_pop = 1'b0;
        evt     = '0;
        if (rx_valid) begin
            evt[EVT_WORD] = 1'b1;
            unique case (st)
                ST_WAIT_HDR: begin
                    if (is_idle) begin
                        st_nxt = ST_WAIT_HDR;
                    end else if (is_hdr) begin
                        if (ref_empty) begin
                            evt[EVT_UNEXP] = 1'b1;
                            st_nxt         = ST_HUNT;
                        end else begin
                            ref_pop = 1'b1;
                            if (ids_match) begin
                                evt[EVT_GOOD] = 1'b1;
                                rem_nxt       = LEN_L;
                                st_nxt        = ST_PAYLOAD;
                            end else begin
                                evt[EVT_MISM] = 1'b1;
                                st_nxt        = ST_HUNT;
                            end
                        end
                    end else begin
                        evt[EVT_FRAME] = 1'b1;
                        st_nxt         = ST_HUNT;
                    end
                end
                ST_PAYLOAD: begin
                    if (is_idle) begin
                        evt[EVT_FRAME]  = 1'b1;
                        evt[EVT_RESYNC] = 1'b1;
                        st_nxt          = ST_WAIT_HDR;
                    end else begin
                        rem_nxt = rem - 1'b1;
                        if (rem == RW'(1)) st_nxt = ST_WAIT_SEP;
                    end
                end
                ST_WAIT_SEP: begin
                    if (is_idle) begin
                        st_nxt = ST_WAIT_HDR;
                    end else begin
                        evt[EVT_FRAME] = 1'b1;
                        st_nxt         = ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (is_idle) begin
                        evt[EVT_RESYNC] = 1'b1;
                        st_nxt          = ST_WAIT_HDR;
                    end
                end
                default: st_nxt = ST_HUNT;
            endcase
        end
    end

    // R5 R6 R7: at most one error class per word
    a_r6_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt[EVT_MISM], evt[EVT_FRAME], evt[EVT_UNEXP]}));
    // R3: payload countdown stays in range
    a_r3_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
        rem <= LEN_L);
    // R9: nothing leaves HUNT except through an idle word
    a_r9_hunt_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT && !(rx_valid && is_idle)) |=> (st == ST_HUNT));
    // R2: a cycle without a valid word leaves the state alone
    a_r2_hold_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(st) && $stable(rem)));

endmodule

// File: rtl/link_sync_checker.sv
module link_sync_checker
    import link_sync_pkg::*;
#(
    parameter int          BX_W        = 12,
    parameter int          EV_W        = 12,
    parameter int          REF_DEPTH   = 16,
    parameter int          PAYLOAD_LEN = 4,
    parameter int          CNT_W       = 32,
    parameter logic [31:0] IDLE_WORD   = 32'hBC50_BC50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [31:0]      rx_word,
    input  logic             trig_accept,
    input  logic [BX_W-1:0]  trig_bx,
    input  logic [EV_W-1:0]  trig_ev,
    input  logic             ctrl_clr,
    output logic [CNT_W-1:0] cnt_words,
    output logic [CNT_W-1:0] cnt_events,
    output logic [CNT_W-1:0] cnt_mismatch,
    output logic [CNT_W-1:0] cnt_framing,
    output logic [CNT_W-1:0] cnt_unexpected,
    output logic [CNT_W-1:0] cnt_resync,
    output logic             err_sticky,
    output logic [BX_W-1:0]  cap_rx_bx,
    output logic [EV_W-1:0]  cap_rx_ev,
    output logic [BX_W-1:0]  cap_ref_bx,
    output logic [EV_W-1:0]  cap_ref_ev
);
    localparam int REF_W = BX_W + EV_W;

    logic [REF_W-1:0]   ref_head;
    logic               ref_empty;
    logic               ref_pop;
    logic [BX_W-1:0]    ref_bx;
    logic [EV_W-1:0]    ref_ev;
    logic [EVT_NUM-1:0] evt;
    logic [BX_W-1:0]    hdr_bx;
    logic [EV_W-1:0]    hdr_ev;
    logic [CNT_W-1:0]   cnt_arr [EVT_NUM];

    assign ref_bx = ref_head[REF_W-1:EV_W];
    assign ref_ev = ref_head[EV_W-1:0];

    ref_fifo #(
        .W     (REF_W),
        .DEPTH (REF_DEPTH)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (trig_accept),
        .din   ({trig_bx, trig_ev}),
        .pop   (ref_pop),
        .dout  (ref_head),
        .empty (ref_empty)
    );

    frame_parser #(
        .BX_W        (BX_W),
        .EV_W        (EV_W),
        .PAYLOAD_LEN (PAYLOAD_LEN),
        .IDLE_WORD   (IDLE_WORD)
    ) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .ref_empty (ref_empty),
        .ref_bx    (ref_bx),
        .ref_ev    (ref_ev),
        .ref_pop   (ref_pop),
        .evt       (evt),
        .hdr_bx    (hdr_bx),
        .hdr_ev    (hdr_ev)
    );

    for (genvar i = 0; i < EVT_NUM; i++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (ctrl_clr),
            .inc   (evt[i]),
            .cnt   (cnt_arr[i])
        );
    end

    assign cnt_words      = cnt_arr[EVT_WORD];
    assign cnt_events     = cnt_arr[EVT_GOOD];
    assign cnt_mismatch   = cnt_arr[EVT_MISM];
    assign cnt_framing    = cnt_arr[EVT_FRAME];
    assign cnt_unexpected = cnt_arr[EVT_UNEXP];
    assign cnt_resync     = cnt_arr[EVT_RESYNC];

    // first-mismatch capture
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_clr) begin
            err_sticky <= 1'b0;
            cap_rx_bx  <= '0;
            cap_rx_ev  <= '0;
            cap_ref_bx <= '0;
            cap_ref_ev <= '0;
        end else if (evt[EVT_MISM] && !err_sticky) begin
            err_sticky <= 1'b1;
            cap_rx_bx  <= hdr_bx;
            cap_rx_ev  <= hdr_ev;
            cap_ref_bx <= ref_bx;
            cap_ref_ev <= ref_ev;
        end
    end

    // R12: captures frozen once sticky
    a_r12_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !ctrl_clr) |=> (err_sticky && $stable(cap_rx_bx) &&
            $stable(cap_rx_ev) && $stable(cap_ref_bx) && $stable(cap_ref_ev)));
    // R12: sticky rises only with a mismatch count step
    a_r12_rise_with_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> (cnt_mismatch != '0));
    // R11: clear drops the sticky flag
    a_r11_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clr |=> !err_sticky);

endmodule

// File: tb/link_sync_checker_tb.sv
`timescale 1ns/1ps
module link_sync_checker_tb;
    localparam int          BXW  = 12;
    localparam int          EVW  = 8;
    localparam int          DEP  = 4;
    localparam int          PLEN = 3;
    localparam int          CW   = 8;
    localparam int          CMAX = 255;
    localparam logic [31:0] IDLE = 32'hBC50_BC50;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [31:0]     rx_word = '0;
    logic            trig_accept = 1'b0;
    logic [BXW-1:0]  trig_bx = '0;
    logic [EVW-1:0]  trig_ev = '0;
    logic            ctrl_clr = 1'b0;
    logic [CW-1:0]   cnt_words, cnt_events, cnt_mismatch, cnt_framing, cnt_unexpected, cnt_resync;
    logic            err_sticky;
    logic [BXW-1:0]  cap_rx_bx, cap_ref_bx;
    logic [EVW-1:0]  cap_rx_ev, cap_ref_ev;

    link_sync_checker #(
        .BX_W(BXW), .EV_W(EVW), .REF_DEPTH(DEP), .PAYLOAD_LEN(PLEN),
        .CNT_W(CW), .IDLE_WORD(IDLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .trig_accept(trig_accept), .trig_bx(trig_bx), .trig_ev(trig_ev),
        .ctrl_clr(ctrl_clr), .cnt_words(cnt_words), .cnt_events(cnt_events),
        .cnt_mismatch(cnt_mismatch), .cnt_framing(cnt_framing),
        .cnt_unexpected(cnt_unexpected), .cnt_resync(cnt_resync),
        .err_sticky(err_sticky), .cap_rx_bx(cap_rx_bx), .cap_rx_ev(cap_rx_ev),
        .cap_ref_bx(cap_ref_bx), .cap_ref_ev(cap_ref_ev)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench protocol model: 0 WAIT_HDR, 1 PAYLOAD, 2 WAIT_SEP, 3 HUNT
    int e_cnt [6];
    int ms = 0;
    int mrem = 0;
    bit e_sticky = 1'b0;
    logic [BXW-1:0] e_rxbx = '0, e_refbx = '0;
    logic [EVW-1:0] e_rxev = '0, e_refev = '0;
    logic [BXW+EVW-1:0] q [$];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] hdr(input logic [BXW-1:0] bx, input logic [EVW-1:0] ev);
        return {8'hE5, 4'h0, ev, bx};
    endfunction

    function automatic logic [31:0] pay();
        logic [31:0] w = $urandom;
        if (w == IDLE) w = w ^ 32'h1;
        return w;
    endfunction

    task automatic bump(input int i);
        if (e_cnt[i] < CMAX) e_cnt[i]++;
    endtask

    task automatic model(input logic [31:0] w);
        logic [BXW+EVW-1:0] r;
        bit idle;
        idle = (w == IDLE);
        bump(0);
        case (ms)
            0: if (!idle) begin
                if (w[31:24] == 8'hE5) begin
                    if (q.size() == 0) begin bump(4); ms = 3; end
                    else begin
                        r = q.pop_front();
                        if (w[BXW-1:0] == r[BXW+EVW-1:EVW] && w[12 +: EVW] == r[EVW-1:0]) begin
                            bump(1); ms = 1; mrem = PLEN;
                        end else begin
                            bump(2); ms = 3;
                            if (!e_sticky) begin
                                e_sticky = 1'b1;
                                e_rxbx = w[BXW-1:0]; e_rxev = w[12 +: EVW];
                                e_refbx = r[BXW+EVW-1:EVW]; e_refev = r[EVW-1:0];
                            end
                        end
                    end
                end else begin bump(3); ms = 3; end
            end
            1: if (idle) begin bump(3); bump(5); ms = 0; end
               else begin mrem--; if (mrem == 0) ms = 2; end
            2: if (idle) ms = 0; else begin bump(3); ms = 3; end
            default: if (idle) begin bump(5); ms = 0; end
        endcase
    endtask

    task automatic drive(input bit v, input logic [31:0] w, input bit t,
                         input logic [BXW-1:0] bx, input logic [EVW-1:0] ev, input bit c);
        @(negedge clk);
        rx_valid = v; rx_word = w; trig_accept = t; trig_bx = bx; trig_ev = ev; ctrl_clr = c;
        if (t && q.size() < DEP) q.push_back({bx, ev});
        if (v) model(w);
        if (c) begin
            for (int i = 0; i < 6; i++) e_cnt[i] = 0;
            e_sticky = 1'b0; e_rxbx = '0; e_rxev = '0; e_refbx = '0; e_refev = '0;
        end
    endtask

    task automatic send(input logic [31:0] w);
        drive(1'b1, w, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic trig(input logic [BXW-1:0] bx, input logic [EVW-1:0] ev);
        drive(1'b0, $urandom, 1'b1, bx, ev, 1'b0);
    endtask

    task automatic frag(input logic [BXW-1:0] bx, input logic [EVW-1:0] ev, input int n);
        send(hdr(bx, ev));
        for (int i = 0; i < n; i++) send(pay());
        send(IDLE);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle_check(input string tag);
        drive(1'b0, $urandom, 1'b0, '0, '0, 1'b0);
        chk({tag, " R2 words"},       int'(cnt_words),      e_cnt[0]);
        chk({tag, " R3 events"},      int'(cnt_events),     e_cnt[1]);
        chk({tag, " R6 mismatch"},    int'(cnt_mismatch),   e_cnt[2]);
        chk({tag, " R7 framing"},     int'(cnt_framing),    e_cnt[3]);
        chk({tag, " R5 unexpected"},  int'(cnt_unexpected), e_cnt[4]);
        chk({tag, " R9 resync"},      int'(cnt_resync),     e_cnt[5]);
        chk({tag, " R12 sticky"},     int'(err_sticky),     int'(e_sticky));
        chk({tag, " R12 cap_rx_bx"},  int'(cap_rx_bx),      int'(e_rxbx));
        chk({tag, " R12 cap_rx_ev"},  int'(cap_rx_ev),      int'(e_rxev));
        chk({tag, " R12 cap_ref_bx"}, int'(cap_ref_bx),     int'(e_refbx));
        chk({tag, " R12 cap_ref_ev"}, int'(cap_ref_ev),     int'(e_refev));
    endtask

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 6; i++) e_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle_check("R1 reset");

        // R2: invalid cycles carrying a header word do nothing
        drive(1'b0, hdr(12'h001, 8'h01), 1'b0, '0, '0, 1'b0);
        settle_check("R2 invalid");

        // R3 R4: good fragments in push order
        trig(12'h010, 8'h20); trig(12'h011, 8'h21); trig(12'h012, 8'h22);
        frag(12'h010, 8'h20, PLEN); send(IDLE);
        frag(12'h011, 8'h21, PLEN); frag(12'h012, 8'h22, PLEN);
        settle_check("R3 good");
        chk("R3 three events", int'(cnt_events), 3);

        // R5: header with empty queue
        frag(12'h100, 8'h40, PLEN);
        settle_check("R5 unexpected");
        chk("R5 one unexpected", int'(cnt_unexpected), 1);

        // R6 R12: first mismatch captured; R9: header in hunt does not pop
        trig(12'h005, 8'h07); trig(12'h0AA, 8'h55);
        send(hdr(12'h006, 8'h07));
        send(hdr(12'h0AA, 8'h55));
        send(pay());
        send(IDLE);
        frag(12'h0AA, 8'h55, PLEN);
        settle_check("R6 R9 mismatch");
        chk("R12 cap rx bx 6", int'(cap_rx_bx), 6);
        chk("R12 cap ref bx 5", int'(cap_ref_bx), 5);

        // R12: second mismatch leaves capture alone
        trig(12'h033, 8'h33);
        frag(12'h033, 8'h34, PLEN);
        settle_check("R12 second");

        // R7: garbage in WAIT_HDR, long fragment
        send(32'h0012_3456); send(IDLE);
        trig(12'h044, 8'h44);
        frag(12'h044, 8'h44, PLEN + 1); send(IDLE);
        settle_check("R7 framing");

        // R8: short fragment
        trig(12'h055, 8'h55);
        frag(12'h055, 8'h55, PLEN - 1);
        settle_check("R8 short");

        // R4: overflow drops the extra pushes
        for (int i = 0; i < DEP + 2; i++) trig(12'h200 + 12'(i), 8'(i));
        for (int i = 0; i < DEP + 1; i++) frag(12'h200 + 12'(i), 8'(i), PLEN);
        send(IDLE);
        settle_check("R4 overflow");

        // constrained random mix
        for (int it = 0; it < 120; it++) begin
            int k = $urandom_range(0, 9);
            logic [BXW-1:0] bx = 12'($urandom);
            logic [EVW-1:0] ev = 8'($urandom);
            if (k != 9) trig(bx, ev);
            if (k <= 5)      frag(bx, ev, PLEN);
            else if (k == 6) frag(bx ^ 12'h1, ev, PLEN);
            else if (k == 7) frag(bx, ev, $urandom_range(0, PLEN - 1));
            else if (k == 8) begin frag(bx, ev, PLEN + 1); send(IDLE); end
            else begin send(32'h00FF_0000 | 32'($urandom_range(0, 65535))); send(IDLE); end
            if ($urandom_range(0, 3) == 0) drive(1'b0, $urandom, 1'b0, '0, '0, 1'b0);
            if (it % 20 == 19) settle_check("R4 R6 R7 random");
        end
        while (q.size() != 0) begin
            logic [BXW+EVW-1:0] r = q[0];
            frag(r[BXW+EVW-1:EVW], r[EVW-1:0], PLEN);
        end
        settle_check("R3 drain");

        // R10: saturation
        for (int i = 0; i < 300; i++) send(IDLE);
        settle_check("R10 saturate");
        chk("R10 words at max", int'(cnt_words), CMAX);

        // R11: clear with a word in the same cycle
        drive(1'b1, IDLE, 1'b0, '0, '0, 1'b1);
        settle_check("R11 clear");
        chk("R11 words zero", int'(cnt_words), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule